// File: doc/BRIEF.md
# Banked SPI Register Access Sequencer

This block accepts register-level requests on a small command port and turns them into chip-select framed byte transactions for a byte-wide SPI serializer. The serializer belongs to an external Ethernet controller whose register file is split into four banks. The sequencer supports the following requests:

- single-register read and write
- 16-bit register-pair write
- bit-field set and bit-field clear
- indirect write to a PHY register

The sequencer keeps a cached copy of the selected bank. It adds a bank-switch pair of transactions only when a register access targets a bank other than the cached one.

Reads of registers in the MAC/MII class need one extra filler byte, and the sequencer adds it. A PHY write is carried out as three ordinary register writes: the index register, then the low and high bytes of the data register pair. After these writes, the sequencer polls a status register until its busy bit clears. A programmable idle gap separates one poll from the next.

Top module: `regacc_seq`

## Requirements
- R1: A request is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high.
  - `cmd_ready` is high only while the sequencer is idle.
  - `rsp_done` is a one-cycle pulse when the request completes.
  - Request codes on `cmd_op`: 0 read, 1 write, 2 pair write, 3 bit set, 4 bit clear, 5 PHY write. Codes 6 and 7 behave as a read.
- R2: Every transaction begins with a command byte, formed as the opcode ORed with address bits [4:0].
  - Opcodes: read 0x00, write 0x40, bit set 0x80, bit clear 0xA0.
  - A write or bit-field transaction sends the data byte second, in the same frame.
- R3: `spi_cs_n` goes low before the first byte of a transaction. It stays low until the last byte's `spi_byte_done`, and then goes high before the next transaction. Each byte after the first is issued only after the previous byte's `spi_byte_done`.
- R4: A read of an address with bit 7 clear sends the command byte followed by one 0x00 filler byte. `rsp_data` returns the byte received during the filler.
- R5: A read of an address with bit 7 set (MAC/MII class) sends two 0x00 filler bytes. `rsp_data` returns the byte received during the second filler.
- R6: The bank of an address is its bits [6:5].
  - Before a read or write whose bank differs from the cached bank, the sequencer sends two bank-switch transactions.
  - The first clears both select bits: 0xBF then 0x03.
  - The second sets the new value: 0x9F then the bank number.
- R7: After reset the cached bank is invalid. The first register read or write therefore switches banks, even when the target is bank 0.
- R8: A register read or write whose bank equals the cached bank sends no bank-switch transactions.
- R9: Bit set and bit clear requests send exactly one transaction and never switch banks. The cached bank is left unchanged.
- R10: A pair write sends two transactions, low byte first:
  - `cmd_data[7:0]` to the given address
  - `cmd_data[15:8]` to the address plus one
- R11: A PHY write runs these steps in order, each with the normal bank handling:
  1. Write `cmd_addr` to register 0xD4.
  2. Write `cmd_data[7:0]` to 0xD6.
  3. Write `cmd_data[15:8]` to 0xD7.
  4. Read status register 0xEA, which is MAC/MII class. Repeat this read while bit 0 of the returned byte is 1.

  `rsp_done` follows the first status read that returns bit 0 clear.
- R12: Between one busy status read and the next, `spi_cs_n` stays high for at least `POLL_GAP` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Sequencer idle, request may be taken |
| cmd_op | input | 3 | Request code |
| cmd_addr | input | 8 | Register descriptor: bit 7 class, bits [6:5] bank, bits [4:0] register; for a PHY write, the PHY register index |
| cmd_data | input | 16 | Write data; low byte for single writes and bit-field requests |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Byte received last; the register value for reads |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_tx_valid | output | 1 | One-cycle pulse starting a byte |
| spi_tx_byte | output | 8 | Byte to shift out |
| spi_byte_done | input | 1 | Serializer finished the current byte |
| spi_rx_byte | input | 8 | Byte shifted in, valid with `spi_byte_done` |

## Verification
The bench instantiates the sequencer with `POLL_GAP` set to 6 and the register addresses left at their defaults. It models the serializer with a two-cycle byte latency.

The short gap keeps the PHY polling scenario brief. It still separates a correct idle gap, of about ten high cycles, from a missing one, of about three. With the default addresses, every bank path can be reached in one short sequence:
- bank 0 from the invalid reset state
- a switch to bank 2 for a MAC-class read
- bank 3 for a pair write
- a 2-then-3 switch inside one PHY write
- a return to bank 1, followed by a repeat access that must not switch

// File: rtl/regacc_pkg.sv
// Shared constants, request codes and helpers for the register access sequencer.
// Assumes 8-bit register descriptors: [7] class, [6:5] bank, [4:0] register.
package regacc_pkg;

    localparam int BYTE_W = 8;
    localparam int BANK_W = 2;

    localparam logic [7:0] SPI_OP_RD   = 8'h00;
    localparam logic [7:0] SPI_OP_WR   = 8'h40;
    localparam logic [7:0] SPI_OP_BSET = 8'h80;
    localparam logic [7:0] SPI_OP_BCLR = 8'hA0;

    localparam logic [7:0] REG_FIELD_MASK  = 8'h1F;
    localparam logic [7:0] BANK_FIELD_MASK = 8'h60;
    localparam int         BANK_SHIFT      = 5;
    localparam int         WIDE_CLASS_BIT  = 7;

    typedef enum logic [2:0] {
        CMD_RD    = 3'd0,
        CMD_WR    = 3'd1,
        CMD_WR16  = 3'd2,
        CMD_BSET  = 3'd3,
        CMD_BCLR  = 3'd4,
        CMD_PHYWR = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        K_RD  = 2'd0,
        K_WR  = 2'd1,
        K_SET = 2'd2,
        K_CLR = 2'd3
    } kind_e;

    typedef struct packed {
        logic [7:0] addr;
        kind_e      kind;
        logic [7:0] data;
    } phase_t;

    function automatic logic [BANK_W-1:0] bank_of(input logic [7:0] a);
        logic [7:0] shifted;
        shifted = (a & BANK_FIELD_MASK) >> BANK_SHIFT;
        return shifted[BANK_W-1:0];
    endfunction

    function automatic logic [7:0] opcode_of(input kind_e k);
        case (k)
            K_RD:    return SPI_OP_RD;
            K_WR:    return SPI_OP_WR;
            K_SET:   return SPI_OP_BSET;
            default: return SPI_OP_BCLR;
        endcase
    endfunction

endpackage

// File: rtl/regacc_bank_cache.sv
// Holds the bank currently selected in the remote device and reports a hit.
// Assumes the cache starts invalid after reset so the first access always switches.
module regacc_bank_cache #(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] query_bank,
    output logic              hit,
    input  logic              load,
    input  logic [BANK_W-1:0] load_bank
);

    logic              valid_q;
    logic [BANK_W-1:0] bank_q;

    // Record the bank once a switch has completed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            bank_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            bank_q  <= load_bank;
        end
    end

    // Compare the requested bank with the cached one.
    always_comb hit = valid_q && (bank_q == query_bank);

    // R8
    cache_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (valid_q && bank_q == $past(load_bank)));

    // R7
    cache_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !valid_q);

endmodule

// File: rtl/regacc_frame.sv
// Runs one chip-select framed transaction of two or three bytes.
// Assumes the serializer answers every tx pulse with exactly one byte_done.
module regacc_frame #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic [CNT_W-1:0]  n_bytes,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              spi_cs_n,
    output logic              spi_tx_valid,
    output logic [BYTE_W-1:0] spi_tx_byte,
    input  logic              spi_byte_done,
    input  logic [BYTE_W-1:0] spi_rx_byte
);

    logic              busy_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  last_q;
    logic [BYTE_W-1:0] data_q;

    // Issue bytes one at a time, paced by byte_done, and frame them with chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q       <= 1'b0;
            idx_q        <= '0;
            last_q       <= '0;
            data_q       <= '0;
            done         <= 1'b0;
            rx_byte      <= '0;
            spi_cs_n     <= 1'b1;
            spi_tx_valid <= 1'b0;
            spi_tx_byte  <= '0;
        end else begin
            spi_tx_valid <= 1'b0;
            done         <= 1'b0;
            if (start && !busy_q) begin
                busy_q       <= 1'b1;
                spi_cs_n     <= 1'b0;
                spi_tx_valid <= 1'b1;
                spi_tx_byte  <= cmd_byte;
                data_q       <= data_byte;
                last_q       <= n_bytes - CNT_W'(1);
                idx_q        <= '0;
            end else if (busy_q && spi_byte_done) begin
                rx_byte <= spi_rx_byte;
                if (idx_q == last_q) begin
                    busy_q   <= 1'b0;
                    spi_cs_n <= 1'b1;
                    done     <= 1'b1;
                end else begin
                    idx_q        <= idx_q + CNT_W'(1);
                    spi_tx_valid <= 1'b1;
                    spi_tx_byte  <= (idx_q == '0) ? data_q : '0;
                end
            end
        end
    end

    // R3
    tx_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_tx_valid |-> !spi_cs_n);

    // R3
    tx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_tx_valid |=> !spi_tx_valid);

    // R3
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spi_cs_n);

endmodule

// File: rtl/regacc_seq.sv
// Turns register requests into framed SPI transactions with bank caching,
// MAC/MII filler bytes and indirect PHY writes with busy polling.
// Assumes one request at a time; a new one is taken only while idle.
module regacc_seq
    import regacc_pkg::*;
#(
    parameter int         POLL_GAP      = 16,
    parameter logic [7:0] SEL_REG       = 8'h1F,
    parameter logic [7:0] SEL_BITS      = 8'h03,
    parameter logic [7:0] PHY_IDX_REG   = 8'hD4,
    parameter logic [7:0] PHY_WLO_REG   = 8'hD6,
    parameter logic [7:0] PHY_STAT_REG  = 8'hEA,
    parameter int         PHY_BUSY_BIT  = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [2:0]  cmd_op,
    input  logic [7:0]  cmd_addr,
    input  logic [15:0] cmd_data,
    output logic        rsp_done,
    output logic [7:0]  rsp_data,
    output logic        spi_cs_n,
    output logic        spi_tx_valid,
    output logic [7:0]  spi_tx_byte,
    input  logic        spi_byte_done,
    input  logic [7:0]  spi_rx_byte
);

    localparam int GAP_W = $clog2(POLL_GAP + 2);
    localparam int CNT_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHK, ST_CLR, ST_SET, ST_ACC, ST_GAP
    } state_e;

    state_e               state_q;
    cmd_e                 req_op;
    logic [7:0]           req_addr;
    logic [15:0]          req_data;
    logic [1:0]           ph_idx;
    logic [GAP_W-1:0]     gap_cnt;
    phase_t               cur;
    logic                 cur_wide;
    logic                 bank_hit;
    logic                 cache_load;
    logic                 fr_start;
    logic [BYTE_W-1:0]    fr_cmd;
    logic [BYTE_W-1:0]    fr_data;
    logic [CNT_W-1:0]     fr_n;
    logic                 fr_done;
    logic [BYTE_W-1:0]    fr_rx;

    // Select the register access of the current phase of the request.
    always_comb begin
        cur.addr = req_addr;
        cur.kind = K_RD;
        cur.data = req_data[7:0];
        case (req_op)
            CMD_WR:   cur.kind = K_WR;
            CMD_BSET: cur.kind = K_SET;
            CMD_BCLR: cur.kind = K_CLR;
            CMD_WR16: begin
                cur.kind = K_WR;
                if (ph_idx != 2'd0) begin
                    cur.addr = req_addr + 8'd1;
                    cur.data = req_data[15:8];
                end
            end
            CMD_PHYWR: begin
                case (ph_idx)
                    2'd0: begin cur.addr = PHY_IDX_REG;        cur.kind = K_WR; cur.data = req_addr;       end
                    2'd1: begin cur.addr = PHY_WLO_REG;        cur.kind = K_WR; cur.data = req_data[7:0];  end
                    2'd2: begin cur.addr = PHY_WLO_REG + 8'd1; cur.kind = K_WR; cur.data = req_data[15:8]; end
                    default: begin cur.addr = PHY_STAT_REG;    cur.kind = K_RD; cur.data = '0;             end
                endcase
            end
            default: cur.kind = K_RD;
        endcase
        cur_wide = (cur.kind == K_RD) && cur.addr[WIDE_CLASS_BIT];
    end

    // Update the bank cache when the set half of a switch completes.
    always_comb cache_load = (state_q == ST_SET) && fr_done;

    regacc_bank_cache #(.BANK_W(BANK_W)) u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .query_bank (bank_of(cur.addr)),
        .hit        (bank_hit),
        .load       (cache_load),
        .load_bank  (bank_of(cur.addr))
    );

    regacc_frame #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (fr_start),
        .cmd_byte      (fr_cmd),
        .data_byte     (fr_data),
        .n_bytes       (fr_n),
        .done          (fr_done),
        .rx_byte       (fr_rx),
        .spi_cs_n      (spi_cs_n),
        .spi_tx_valid  (spi_tx_valid),
        .spi_tx_byte   (spi_tx_byte),
        .spi_byte_done (spi_byte_done),
        .spi_rx_byte   (spi_rx_byte)
    );

    // Ready only while idle.
    always_comb cmd_ready = (state_q == ST_IDLE);

    // Step through bank check, switch, access, next phase and poll gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            req_op   <= CMD_RD;
            req_addr <= '0;
            req_data <= '0;
            ph_idx   <= '0;
            gap_cnt  <= '0;
            fr_start <= 1'b0;
            fr_cmd   <= '0;
            fr_data  <= '0;
            fr_n     <= 2'd2;
            rsp_done <= 1'b0;
            rsp_data <= '0;
        end else begin
            fr_start <= 1'b0;
            rsp_done <= 1'b0;
            case (state_q)
                ST_IDLE: if (cmd_valid) begin
                    req_op   <= cmd_e'(cmd_op);
                    req_addr <= cmd_addr;
                    req_data <= cmd_data;
                    ph_idx   <= '0;
                    state_q  <= ST_CHK;
                end
                ST_CHK: begin
                    fr_start <= 1'b1;
                    if (cur.kind == K_SET || cur.kind == K_CLR || bank_hit) begin
                        fr_cmd  <= opcode_of(cur.kind) | (cur.addr & REG_FIELD_MASK);
                        fr_data <= (cur.kind == K_RD) ? 8'h00 : cur.data;
                        fr_n    <= cur_wide ? 2'd3 : 2'd2;
                        state_q <= ST_ACC;
                    end else begin
                        fr_cmd  <= SPI_OP_BCLR | (SEL_REG & REG_FIELD_MASK);
                        fr_data <= SEL_BITS;
                        fr_n    <= 2'd2;
                        state_q <= ST_CLR;
                    end
                end
                ST_CLR: if (fr_done) begin
                    fr_start <= 1'b1;
                    fr_cmd   <= SPI_OP_BSET | (SEL_REG & REG_FIELD_MASK);
                    fr_data  <= {{(BYTE_W-BANK_W){1'b0}}, bank_of(cur.addr)};
                    fr_n     <= 2'd2;
                    state_q  <= ST_SET;
                end
                ST_SET: if (fr_done) state_q <= ST_CHK;
                ST_ACC: if (fr_done) begin
                    if (req_op == CMD_WR16 && ph_idx == 2'd0) begin
                        ph_idx  <= 2'd1;
                        state_q <= ST_CHK;
                    end else if (req_op == CMD_PHYWR && ph_idx != 2'd3) begin
                        ph_idx  <= ph_idx + 2'd1;
                        state_q <= ST_CHK;
                    end else if (req_op == CMD_PHYWR && fr_rx[PHY_BUSY_BIT]) begin
                        gap_cnt <= GAP_W'(POLL_GAP);
                        state_q <= ST_GAP;
                    end else begin
                        rsp_done <= 1'b1;
                        rsp_data <= fr_rx;
                        state_q  <= ST_IDLE;
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == '0) state_q <= ST_CHK;
                    else               gap_cnt <= gap_cnt - GAP_W'(1);
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1
    accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R12
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (spi_cs_n && !spi_tx_valid));

    // R9
    bitfield_no_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHK && (req_op == CMD_BSET || req_op == CMD_BCLR)) |=> (state_q == ST_ACC));

endmodule

// File: tb/regacc_seq_test.sv
// Scoreboard bench: driver tasks queue the expected SPI bytes, a serializer
// model at the negative edge pops and compares them as the design issues them.
module regacc_seq_test;
    import regacc_pkg::*;

    localparam int GAP = 6;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [2:0]  cmd_op;
    logic [7:0]  cmd_addr;
    logic [15:0] cmd_data;
    logic        rsp_done;
    logic [7:0]  rsp_data;
    logic        spi_cs_n;
    logic        spi_tx_valid;
    logic [7:0]  spi_tx_byte;
    logic        spi_byte_done;
    logic [7:0]  spi_rx_byte;

    always #4 clk = ~clk;

    regacc_seq #(.POLL_GAP(GAP)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rsp_done(rsp_done), .rsp_data(rsp_data),
        .spi_cs_n(spi_cs_n), .spi_tx_valid(spi_tx_valid), .spi_tx_byte(spi_tx_byte),
        .spi_byte_done(spi_byte_done), .spi_rx_byte(spi_rx_byte)
    );

    typedef struct packed {
        logic       first;
        logic       gap;
        logic [7:0] tx;
        logic [7:0] rx;
        logic [7:0] req;
    } xb_t;

    xb_t        exp_q[$];
    int         n_tests = 0;
    int         n_fail = 0;
    int         model_bank = -1;
    int         hi_cnt = 0;
    bit         pend = 1'b0;
    int         lat_cnt = 0;
    logic [7:0] pend_rx = 8'h00;
    bit         finished = 1'b0;

    task automatic check(input bit ok, input int rq, input string what, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", rq, what, act, expv);
        end
    endtask

    task automatic push_frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] rx1,
                              input bit wide, input logic [7:0] rx2, input bit gap, input int rq);
        exp_q.push_back(xb_t'{first: 1'b1, gap: gap, tx: b0, rx: 8'h00, req: 8'(rq)});
        exp_q.push_back(xb_t'{first: 1'b0, gap: 1'b0, tx: b1, rx: rx1, req: 8'(rq)});
        if (wide) exp_q.push_back(xb_t'{first: 1'b0, gap: 1'b0, tx: 8'h00, rx: rx2, req: 8'(rq)});
    endtask

    // Model of one register access: kind 0 read, 1 write, 2 bit set, 3 bit clear.
    task automatic exp_access(input logic [7:0] addr, input int kind, input logic [7:0] data,
                              input logic [7:0] rxv, input bit gap, input int rq);
        int b;
        logic [7:0] op;
        bit wide;
        b = int'((addr >> 5) & 8'h03);
        if (kind < 2 && b != model_bank) begin
            // R6 clear then set; R7 first access always switches
            push_frame(8'hBF, 8'h03, 8'h00, 1'b0, 8'h00, 1'b0, 6);
            push_frame(8'h9F, 8'(b), 8'h00, 1'b0, 8'h00, 1'b0, 6);
            model_bank = b;
        end
        op = (kind == 0) ? 8'h00 : (kind == 1) ? 8'h40 : (kind == 2) ? 8'h80 : 8'hA0;
        wide = (kind == 0) && addr[7];
        if (wide) push_frame(op | (addr & 8'h1F), 8'h00, 8'h33, 1'b1, rxv, gap, rq);
        else      push_frame(op | (addr & 8'h1F), (kind == 0) ? 8'h00 : data, rxv, 1'b0, 8'h00, gap, rq);
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [7:0] addr, input logic [15:0] data,
                          input bit chk_rd, input logic [7:0] exp_rd, input int rq);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        // R1 ready drops once the request is taken
        check(!cmd_ready, 1, "ready while busy", int'(cmd_ready), 0);
        while (!rsp_done) @(negedge clk);
        if (chk_rd) check(rsp_data == exp_rd, rq, "read data", int'(rsp_data), int'(exp_rd));
        check(exp_q.size() == 0, rq, "bytes left unsent", exp_q.size(), 0);
        @(negedge clk);
        // R1 done is a single-cycle pulse
        check(!rsp_done, 1, "done pulse width", int'(rsp_done), 0);
    endtask

    // Serializer model and scoreboard monitor.
    initial begin
        spi_byte_done = 1'b0;
        spi_rx_byte = 8'h00;
        forever begin
            @(negedge clk);
            spi_byte_done = 1'b0;
            if (pend) begin
                if (lat_cnt == 0) begin
                    spi_byte_done = 1'b1;
                    spi_rx_byte = pend_rx;
                    pend = 1'b0;
                end else lat_cnt--;
            end
            if (rst_n && spi_tx_valid) begin
                xb_t e;
                if (exp_q.size() == 0) begin
                    // R2 no byte may appear that the model did not predict
                    check(1'b0, 2, "unexpected byte", int'(spi_tx_byte), 0);
                    pend_rx = 8'h00;
                end else begin
                    e = exp_q.pop_front();
                    // R2 R4 R5 R6 R10 R11 byte content
                    check(spi_tx_byte == e.tx, int'(e.req), "tx byte", int'(spi_tx_byte), int'(e.tx));
                    // R3 framing
                    if (e.first) check(hi_cnt > 0, 3, "cs high before frame", hi_cnt, 1);
                    else         check(hi_cnt == 0, 3, "cs held inside frame", hi_cnt, 0);
                    // R12 poll gap
                    if (e.gap) check(hi_cnt >= GAP, 12, "poll gap cycles", hi_cnt, GAP);
                    pend_rx = e.rx;
                end
                pend = 1'b1;
                lat_cnt = LAT - 1;
                hi_cnt = 0;
            end else if (spi_cs_n) hi_cnt++;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, 1, "watchdog expired", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_addr = 8'h00; cmd_data = 16'h0;
        repeat (4) @(negedge clk);
        // reset state
        check(spi_cs_n == 1'b1, 3, "reset cs_n", int'(spi_cs_n), 1);
        check(spi_tx_valid == 1'b0, 3, "reset tx_valid", int'(spi_tx_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1, 1, "ready after reset", int'(cmd_ready), 1);
        check(rsp_done == 1'b0, 1, "done after reset", int'(rsp_done), 0);

        // R7 R4: first read of bank 0 switches anyway
        exp_access(8'h05, 0, 8'h00, 8'h5A, 1'b0, 4);
        do_cmd(3'(CMD_RD), 8'h05, 16'h0, 1'b1, 8'h5A, 4);

        // R8 R2: same bank, plain write, no switch
        exp_access(8'h06, 1, 8'h11, 8'h00, 1'b0, 8);
        do_cmd(3'(CMD_WR), 8'h06, 16'h0011, 1'b0, 8'h00, 8);

        // R5 R6: MAC-class read in bank 2, second filler returned
        exp_access(8'hC0, 0, 8'h00, 8'h77, 1'b0, 5);
        do_cmd(3'(CMD_RD), 8'hC0, 16'h0, 1'b1, 8'h77, 5);

        // R9: bit-field requests never switch and leave the cache at bank 2
        exp_access(8'h1F, 2, 8'h04, 8'h00, 1'b0, 9);
        do_cmd(3'(CMD_BSET), 8'h1F, 16'h0004, 1'b0, 8'h00, 9);
        exp_access(8'h3B, 3, 8'h80, 8'h00, 1'b0, 9);
        do_cmd(3'(CMD_BCLR), 8'h3B, 16'h0080, 1'b0, 8'h00, 9);
        // R9: cache still bank 2, so a bank-2 read needs no switch
        exp_access(8'h41, 0, 8'h00, 8'h2C, 1'b0, 9);
        do_cmd(3'(CMD_RD), 8'h41, 16'h0, 1'b1, 8'h2C, 9);

        // R10: pair write to bank 3, low byte first
        exp_access(8'h68, 1, 8'hEF, 8'h00, 1'b0, 10);
        exp_access(8'h69, 1, 8'hBE, 8'h00, 1'b0, 10);
        do_cmd(3'(CMD_WR16), 8'h68, 16'hBEEF, 1'b0, 8'h00, 10);

        // R11 R12: PHY write with two busy polls
        exp_access(8'hD4, 1, 8'h14, 8'h00, 1'b0, 11);
        exp_access(8'hD6, 1, 8'h34, 8'h00, 1'b0, 11);
        exp_access(8'hD7, 1, 8'h12, 8'h00, 1'b0, 11);
        exp_access(8'hEA, 0, 8'h00, 8'h01, 1'b0, 11);
        exp_access(8'hEA, 0, 8'h00, 8'h01, 1'b1, 12);
        exp_access(8'hEA, 0, 8'h00, 8'h00, 1'b1, 12);
        do_cmd(3'(CMD_PHYWR), 8'h14, 16'h1234, 1'b1, 8'h00, 11);

        // R6 R4: return to bank 1, then R8 repeat with no switch
        exp_access(8'h25, 0, 8'h00, 8'h9D, 1'b0, 6);
        do_cmd(3'(CMD_RD), 8'h25, 16'h0, 1'b1, 8'h9D, 6);
        exp_access(8'h25, 0, 8'h00, 8'h4E, 1'b0, 8);
        do_cmd(3'(CMD_RD), 8'h25, 16'h0, 1'b1, 8'h4E, 8);

        repeat (10) @(negedge clk);
        // R3 idle line after the last request
        check(spi_cs_n == 1'b1, 3, "cs_n idle", int'(spi_cs_n), 1);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule